// File: doc/BRIEF.md
# Memory Wiring and Cell Self-Test Engine

This block is a hardware self-test sequencer for a single-port synchronous RAM that is attached to it. A start pulse launches three phases that always run in the same order. The first checks the data lines, the second checks the address lines, and the third checks every cell of the region. Each phase trusts the one before it, so the phase that fails points at the likely fault. The data phase proves that every data line toggles on its own. The address phase writes to power-of-two offsets and looks for aliasing. The device phase then fills the region with values that follow the address, so a memory that holds no real storage cannot pass.

Software supplies a base address and the base-two logarithm of the region size in words. The low address bits that the region covers are taken as zero, whatever the supplied base holds in them. The engine owns the memory port for the whole run. A read returns its data in the cycle after the read enable. When the run ends, the engine reports done and pass, together with the failing phase, the failing absolute address and a data word.

Top module: `memtest_engine`

## Requirements
- R1: After reset, busy, done and pass are 0, fail_phase is 0, and neither mem_we nor mem_re is asserted.
- R2: A start seen while the engine is idle latches base_addr and region_lg, and busy is 1 from the next cycle until the run ends. A start seen while busy is ignored, and the access sequence and the result are unchanged.
- R3: The data phase first. For each bit i from 0 to DW-1, the engine writes a word that has only bit i set to the region base, then reads it back in the next cycle. A mismatch ends the run with fail_phase 1, fail_addr equal to the region base, and fail_data equal to the pattern written.
- R4: The address phase (fail_phase 2). The engine writes PAT to base+2^i for every i below region_lg. PAT has every odd-numbered bit set: 0xAA when DW is 8. It then writes ~PAT to base+0 and reads every power-of-two offset. A read that is not PAT ends the run, reporting the address that was read and the value that was read. Finally it writes PAT back to base+0.
- R5: Next, for each power-of-two offset T in ascending order, the engine writes ~PAT to base+T and reads every power-of-two offset in ascending order, including T. A read at an offset other than T that is not PAT ends the run, reporting base+T and the value that was read. The engine then writes PAT back to base+T.
- R6: The device phase (fail_phase 3). The engine writes (k+1) mod 2^DW to every offset k in ascending order. Pass two reads each k, expects k+1 and then writes ~(k+1). Pass three reads each k, expects ~(k+1) and then writes 0. A mismatch reports base+k and the value that was read.
- R7: The port performs at most one access per cycle and never asserts mem_we and mem_re together. Read data is compared in the cycle after the read enable.
- R8: A mismatch ends the run at once. No further memory access follows, busy drops, done becomes 1, pass stays 0, and fail_phase holds the code of the failing phase.
- R9: When all phases succeed, every word of the region holds 0, done and pass are 1, and fail_phase is 0. The results hold until the next accepted start.
- R10: The low region_lg bits of base_addr are ignored. A region_lg above AW is treated as AW. A region_lg of 0 skips the address phase and tests the single word at the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run request, taken while idle |
| base_addr | input | AW | Region base word address |
| region_lg | input | LGW | Log2 of the region size in words |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after mem_re |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| pass | output | 1 | All phases succeeded |
| fail_phase | output | 2 | 0 none, 1 data, 2 address, 3 device |
| fail_addr | output | AW | Absolute address of the failure |
| fail_data | output | DW | Pattern (data phase) or value read (other phases) |

## Verification
The bench attaches a memory model to the port and gives it injected faults: a data line stuck high, an address line stuck low, a wired-OR short between two address lines, one stuck cell, and a missing chip whose reads return the charge left on the bus. The missing chip has to pass the data phase and be caught by the address phase. An engine that checked each read right after its write in the device phase would let that chip through. The short aliases two nonzero power-of-two offsets, so only the per-offset loop sees it. An engine that reported the offset it read instead of the offset under test would return the wrong address. Unaligned bases, a clamped oversized region, a one-word region and a start pulse in mid-run test the address forming and the start handling. A wrong mask, a skipped restore, or an engine that restarted on the second start would all send the access order away from the model's.

// File: rtl/memtest_pkg.sv
// Shared types for the memory self-test engine.
// Assumes nothing beyond a synchronous single-port RAM with one cycle of read latency.
package memtest_pkg;

    // Failing phase code reported at the top level
    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_DATA = 2'd1,
        PH_ADDR = 2'd2,
        PH_DEV  = 2'd3
    } phase_e;

    // Sequencer states: one memory access or one compare per state
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DW,   // data phase: write walking one
        ST_DR,   // data phase: read back
        ST_DC,   // data phase: compare
        ST_AF,   // address phase: fill power-of-two offsets
        ST_AZ,   // address phase: write inverse at offset under test
        ST_AR,   // address phase: read a power-of-two offset
        ST_AC,   // address phase: compare
        ST_AX,   // address phase: restore offset under test
        ST_VF,   // device phase: incrementing fill
        ST_V2R,  // device pass two: read
        ST_V2C,  // device pass two: compare
        ST_V2W,  // device pass two: write inverse
        ST_V3R,  // device pass three: read
        ST_V3C,  // device pass three: compare
        ST_V3W   // device pass three: write zero
    } state_e;

endpackage

// File: rtl/mt_offsets.sv
// Offset and loop-end helper for the self-test sequencer.
// Produces the region mask, the power-of-two offsets for two indices, and the
// last-iteration flags. Assumes lg never exceeds AW (the top clamps it).
module mt_offsets #(
    parameter int AW  = 8,
    parameter int LGW = 4,
    parameter int IW  = 4
) (
    input  logic [LGW-1:0] lg,
    input  logic [IW-1:0]  idx,
    input  logic [IW-1:0]  tsel,
    input  logic [AW-1:0]  k,
    output logic [AW-1:0]  mask,
    output logic [AW-1:0]  pow_idx,
    output logic [AW-1:0]  pow_t,
    output logic           idx_last,
    output logic           tsel_last,
    output logic           k_last
);

    // Region mask: 2^lg - 1, wrapping to all ones when lg equals AW
    always_comb mask = (AW'(1) << lg) - AW'(1);

    // Power-of-two offsets for the read index and the test index
    always_comb begin
        pow_idx = AW'(1) << idx;
        pow_t   = AW'(1) << tsel;
    end

    // Loop-end flags for the index loops and the word loop
    always_comb begin
        idx_last  = (int'(idx)  == int'(lg) - 1);
        tsel_last = (int'(tsel) == int'(lg) - 1);
        k_last    = (k == mask);
    end

endmodule

// File: rtl/mt_patterns.sv
// Test data generator: walking one, alternating pattern and its inverse,
// and the incrementing word value with its inverse for the device passes.
// Purely combinational; assumes idx is below DW during the data phase.
module mt_patterns #(
    parameter int DW = 8,
    parameter int AW = 8,
    parameter int IW = 4
) (
    input  logic [IW-1:0] idx,
    input  logic [AW-1:0] k,
    output logic [DW-1:0] walk,
    output logic [DW-1:0] pat,
    output logic [DW-1:0] anti,
    output logic [DW-1:0] inc,
    output logic [DW-1:0] inc_n
);

    // Alternating pattern: odd-numbered bits set
    for (genvar b = 0; b < DW; b++) begin : g_alt
        assign pat[b] = 1'(b % 2);
    end

    // Inverse pattern and walking one
    always_comb begin
        anti = ~pat;
        walk = DW'(1) << idx;
    end

    // Incrementing value for word k and its inverse
    always_comb begin
        inc   = DW'(k) + DW'(1);
        inc_n = ~inc;
    end

endmodule

// File: rtl/mt_check.sv
// Read-data comparator and result store.
// Flags a mismatch in the compare cycle and latches phase, address and data.
// The result holds until clear, which the top raises when it accepts a start.
module mt_check
    import memtest_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          chk_en,
    input  logic          rep_pattern,
    input  logic          finish_ok,
    input  phase_e        rep_phase,
    input  logic [DW-1:0] exp_data,
    input  logic [DW-1:0] rdata,
    input  logic [AW-1:0] rep_addr,
    output logic          mismatch,
    output logic          done,
    output logic          pass,
    output phase_e        fail_phase,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_data
);

    // Compare the returned word against the expected one
    always_comb mismatch = chk_en && (rdata != exp_data);

    // Latch the run outcome; first event wins, held until clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            done       <= 1'b0;
            pass       <= 1'b0;
            fail_phase <= PH_NONE;
            fail_addr  <= '0;
            fail_data  <= '0;
        end else if (mismatch) begin
            done       <= 1'b1;
            pass       <= 1'b0;
            fail_phase <= rep_phase;
            fail_addr  <= rep_addr;
            fail_data  <= rep_pattern ? exp_data : rdata;
        end else if (finish_ok) begin
            done <= 1'b1;
            pass <= 1'b1;
        end
    end

endmodule

// File: rtl/memtest_engine.sv
// Memory self-test engine, top level.
// Runs the data-line, address-line and device phases in order against a
// synchronous RAM port with one cycle of read latency. One access per state;
// a read costs two cycles (issue, compare). Assumes the RAM is not shared
// during a run. The low region_lg bits of the base are forced to zero.
module memtest_engine
    import memtest_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    localparam int LGW = $clog2(AW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-1:0]  base_addr,
    input  logic [LGW-1:0] region_lg,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_we,
    output logic           mem_re,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic           busy,
    output logic           done,
    output logic           pass,
    output logic [1:0]     fail_phase,
    output logic [AW-1:0]  fail_addr,
    output logic [DW-1:0]  fail_data
);

    localparam int DIW = (DW > 1) ? $clog2(DW) : 1;
    localparam int IW  = (DIW > LGW) ? DIW : LGW;

    state_e         state;
    logic [AW-1:0]  base_q;
    logic [AW-1:0]  k_q;
    logic [LGW-1:0] lg_q;
    logic [IW-1:0]  idx_q;
    logic [IW-1:0]  tsel_q;
    logic           tzero_q;

    logic [AW-1:0]  mask, pow_idx, pow_t;
    logic           idx_last, tsel_last, k_last;
    logic [DW-1:0]  walk, pat, anti, inc, inc_n;

    logic [AW-1:0]  off, rep_off, rep_addr;
    logic [DW-1:0]  exp_data;
    logic           chk_en, rep_pattern, finish_ok, clear, mismatch;
    phase_e         rep_phase, fail_phase_e;

    mt_offsets #(.AW(AW), .LGW(LGW), .IW(IW)) u_off (
        .lg        (lg_q),
        .idx       (idx_q),
        .tsel      (tsel_q),
        .k         (k_q),
        .mask      (mask),
        .pow_idx   (pow_idx),
        .pow_t     (pow_t),
        .idx_last  (idx_last),
        .tsel_last (tsel_last),
        .k_last    (k_last)
    );

    mt_patterns #(.DW(DW), .AW(AW), .IW(IW)) u_pat (
        .idx   (idx_q),
        .k     (k_q),
        .walk  (walk),
        .pat   (pat),
        .anti  (anti),
        .inc   (inc),
        .inc_n (inc_n)
    );

    // Start acceptance, run end and busy status
    always_comb begin
        clear     = (state == ST_IDLE) && start;
        finish_ok = (state == ST_V3W) && k_last;
        busy      = (state != ST_IDLE);
    end

    // Decode the current state into one memory access
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        off       = '0;
        mem_wdata = '0;
        unique case (state)
            ST_DW:  begin mem_we = 1'b1; mem_wdata = walk; end
            ST_DR:  mem_re = 1'b1;
            ST_AF:  begin mem_we = 1'b1; off = pow_idx; mem_wdata = pat; end
            ST_AZ:  begin mem_we = 1'b1; off = tzero_q ? '0 : pow_t; mem_wdata = anti; end
            ST_AR:  begin mem_re = 1'b1; off = pow_idx; end
            ST_AX:  begin mem_we = 1'b1; off = tzero_q ? '0 : pow_t; mem_wdata = pat; end
            ST_VF:  begin mem_we = 1'b1; off = k_q; mem_wdata = inc; end
            ST_V2R: begin mem_re = 1'b1; off = k_q; end
            ST_V2W: begin mem_we = 1'b1; off = k_q; mem_wdata = inc_n; end
            ST_V3R: begin mem_re = 1'b1; off = k_q; end
            ST_V3W: begin mem_we = 1'b1; off = k_q; end
            default: ;
        endcase
    end

    // Decode the compare states: expected word, report address and phase
    always_comb begin
        chk_en      = 1'b0;
        exp_data    = '0;
        rep_off     = '0;
        rep_phase   = PH_NONE;
        rep_pattern = 1'b0;
        unique case (state)
            ST_DC: begin
                chk_en      = 1'b1;
                exp_data    = walk;
                rep_phase   = PH_DATA;
                rep_pattern = 1'b1;
            end
            ST_AC: begin
                chk_en    = tzero_q || (idx_q != tsel_q);
                exp_data  = pat;
                rep_off   = tzero_q ? pow_idx : pow_t;
                rep_phase = PH_ADDR;
            end
            ST_V2C: begin
                chk_en    = 1'b1;
                exp_data  = inc;
                rep_off   = k_q;
                rep_phase = PH_DEV;
            end
            ST_V3C: begin
                chk_en    = 1'b1;
                exp_data  = inc_n;
                rep_off   = k_q;
                rep_phase = PH_DEV;
            end
            default: ;
        endcase
    end

    // Absolute addresses: aligned base with the region offset
    always_comb begin
        mem_addr = (base_q & ~mask) | (off & mask);
        rep_addr = (base_q & ~mask) | (rep_off & mask);
    end

    // Phase sequencer: walks the three phases and stops on a mismatch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            base_q  <= '0;
            lg_q    <= '0;
            k_q     <= '0;
            idx_q   <= '0;
            tsel_q  <= '0;
            tzero_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    base_q <= base_addr;
                    lg_q   <= (int'(region_lg) > AW) ? LGW'(AW) : region_lg;
                    idx_q  <= '0;
                    state  <= ST_DW;
                end
                ST_DW: state <= ST_DR;
                ST_DR: state <= ST_DC;
                ST_DC: begin
                    if (mismatch) begin
                        state <= ST_IDLE;
                    end else if (idx_q == IW'(DW - 1)) begin
                        idx_q <= '0;
                        k_q   <= '0;
                        state <= (lg_q == '0) ? ST_VF : ST_AF;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                        state <= ST_DW;
                    end
                end
                ST_AF: begin
                    if (idx_last) begin
                        idx_q   <= '0;
                        tzero_q <= 1'b1;
                        state   <= ST_AZ;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
                ST_AZ: begin
                    idx_q <= '0;
                    state <= ST_AR;
                end
                ST_AR: state <= ST_AC;
                ST_AC: begin
                    if (mismatch) begin
                        state <= ST_IDLE;
                    end else if (idx_last) begin
                        state <= ST_AX;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                        state <= ST_AR;
                    end
                end
                ST_AX: begin
                    if (tzero_q) begin
                        tzero_q <= 1'b0;
                        tsel_q  <= '0;
                        state   <= ST_AZ;
                    end else if (tsel_last) begin
                        k_q   <= '0;
                        state <= ST_VF;
                    end else begin
                        tsel_q <= tsel_q + IW'(1);
                        state  <= ST_AZ;
                    end
                end
                ST_VF: begin
                    if (k_last) begin
                        k_q   <= '0;
                        state <= ST_V2R;
                    end else begin
                        k_q <= k_q + AW'(1);
                    end
                end
                ST_V2R: state <= ST_V2C;
                ST_V2C: state <= mismatch ? ST_IDLE : ST_V2W;
                ST_V2W: begin
                    if (k_last) begin
                        k_q   <= '0;
                        state <= ST_V3R;
                    end else begin
                        k_q   <= k_q + AW'(1);
                        state <= ST_V2R;
                    end
                end
                ST_V3R: state <= ST_V3C;
                ST_V3C: state <= mismatch ? ST_IDLE : ST_V3W;
                ST_V3W: begin
                    if (k_last) begin
                        state <= ST_IDLE;
                    end else begin
                        k_q   <= k_q + AW'(1);
                        state <= ST_V3R;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    mt_check #(.AW(AW), .DW(DW)) u_chk (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .chk_en      (chk_en),
        .rep_pattern (rep_pattern),
        .finish_ok   (finish_ok),
        .rep_phase   (rep_phase),
        .exp_data    (exp_data),
        .rdata       (mem_rdata),
        .rep_addr    (rep_addr),
        .mismatch    (mismatch),
        .done        (done),
        .pass        (pass),
        .fail_phase  (fail_phase_e),
        .fail_addr   (fail_addr),
        .fail_data   (fail_data)
    );

    // Export the phase code as a plain vector
    always_comb fail_phase = fail_phase_e;

endmodule

// File: rtl/memtest_engine_chk.sv
// Property checker for the memory self-test engine, attached by bind.
// Watches the memory port, the status outputs and the latched base.
module memtest_engine_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_we,
    input logic          mem_re,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic [1:0]    fail_phase,
    input logic [AW-1:0] base_q,
    input logic [DW-1:0] mem_wdata
);

    // R7: never a write and a read in the same cycle
    a_r7_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R2: an accepted start makes the engine busy in the next cycle
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2: the latched base does not move during a run
    a_r2_base_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(base_q));

    // R8: the port is quiet whenever the engine is idle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_we || mem_re));

    // R8: done and busy are never high together
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R8: a finished run without pass carries a phase code
    a_r8_fail_has_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (fail_phase != 2'd0));

    // R9: pass comes only with done and no phase code
    a_r9_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (done && fail_phase == 2'd0));

    // R9: done rises only at the end of a busy run
    a_r9_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R7: write data is zero outside write cycles
    a_r7_wdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (mem_wdata == '0));

endmodule

bind memtest_engine memtest_engine_chk #(.AW(AW), .DW(DW)) u_prop (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .fail_phase (fail_phase),
    .base_q     (base_q),
    .mem_wdata  (mem_wdata)
);

// File: tb/memtest_engine_tb.sv
// Bench for the memory self-test engine: a faultable RAM model on the port,
// a behavioural reference that predicts every access and the outcome, and
// a per-clock comparison of port activity against the predicted queue.
module memtest_engine_tb;

    localparam int AW  = 8;
    localparam int DW  = 8;
    localparam int LGW = $clog2(AW + 1);
    localparam int NW  = 1 << AW;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start;
    logic [AW-1:0]  base_addr;
    logic [LGW-1:0] region_lg;
    logic [AW-1:0]  mem_addr;
    logic           mem_we, mem_re;
    logic [DW-1:0]  mem_wdata;
    logic [DW-1:0]  mem_rdata;
    logic           busy, done, pass;
    logic [1:0]     fail_phase;
    logic [AW-1:0]  fail_addr;
    logic [DW-1:0]  fail_data;

    always #4 clk = ~clk;

    memtest_engine #(.AW(AW), .DW(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .base_addr  (base_addr),
        .region_lg  (region_lg),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .pass       (pass),
        .fail_phase (fail_phase),
        .fail_addr  (fail_addr),
        .fail_data  (fail_data)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Fault selection: 0 none, 1 data bit stuck high, 2 address bit stuck low,
    // 3 missing chip, 4 address bit stuck high, 5 stuck cell, 6 wired-OR short
    int            fault_kind = 0;
    int            fault_bit  = 0;
    logic [AW-1:0] fault_cell = '0;

    logic [DW-1:0] live_mem [NW];
    logic [DW-1:0] live_last;
    logic [DW-1:0] ref_mem  [NW];
    logic [DW-1:0] ref_last;

    typedef struct packed {
        logic          we;
        logic          re;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } op_t;

    op_t   exp_q[$];
    string tag_q[$];

    logic          e_pass;
    logic [1:0]    e_phase;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;

    function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
        logic [AW-1:0] p = a;
        case (fault_kind)
            2: p[fault_bit] = 1'b0;
            4: p[fault_bit] = 1'b1;
            6: if (a[fault_bit] || a[fault_bit+1]) begin
                   p[fault_bit]   = 1'b1;
                   p[fault_bit+1] = 1'b1;
               end
            default: ;
        endcase
        return p;
    endfunction

    function automatic logic [DW-1:0] stor(input logic [AW-1:0] pa, input logic [DW-1:0] d);
        logic [DW-1:0] v = d;
        if (fault_kind == 1) v[fault_bit] = 1'b1;
        if (fault_kind == 5 && pa == fault_cell) v[DW-1] = 1'b1;
        return v;
    endfunction

    function automatic logic [DW-1:0] alt_pat();
        logic [DW-1:0] v = '0;
        for (int b = 1; b < DW; b += 2) v[b] = 1'b1;
        return v;
    endfunction

    // RAM model on the port, one cycle read latency
    always @(posedge clk) begin
        if (mem_we) begin
            live_mem[phys(mem_addr)] <= stor(phys(mem_addr), mem_wdata);
            live_last <= mem_wdata;
        end
        if (mem_re) mem_rdata <= (fault_kind == 3) ? live_last : live_mem[phys(mem_addr)];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ref_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tg);
        exp_q.push_back('{we: 1'b1, re: 1'b0, a: a, d: d});
        tag_q.push_back(tg);
        ref_mem[phys(a)] = stor(phys(a), d);
        ref_last = d;
    endtask

    task automatic ref_rd(input logic [AW-1:0] a, input string tg, output logic [DW-1:0] v);
        exp_q.push_back('{we: 1'b0, re: 1'b1, a: a, d: '0});
        tag_q.push_back(tg);
        v = (fault_kind == 3) ? ref_last : ref_mem[phys(a)];
    endtask

    // Reference: predicted access list and outcome for one run
    task automatic ref_run(input logic [AW-1:0] base, input int lg_in);
        int lg;
        logic [AW-1:0] msk, b, toff;
        logic [DW-1:0] v, p, pt, an;
        lg = (lg_in > AW) ? AW : lg_in;
        msk = AW'((1 << lg) - 1);
        b = base & ~msk;
        for (int i = 0; i < NW; i++) ref_mem[i] = live_mem[i];
        ref_last = live_last;
        e_pass = 1'b0; e_phase = 2'd0; e_addr = '0; e_data = '0;
        for (int i = 0; i < DW; i++) begin
            p = DW'(1) << i;
            ref_wr(b, p, "R3");
            ref_rd(b, "R3", v);
            if (v != p) begin e_phase = 2'd1; e_addr = b; e_data = p; return; end
        end
        pt = alt_pat();
        an = ~pt;
        if (lg > 0) begin
            for (int i = 0; i < lg; i++) ref_wr(b | (AW'(1) << i), pt, "R4");
            for (int t = -1; t < lg; t++) begin
                toff = (t < 0) ? '0 : (AW'(1) << t);
                ref_wr(b | toff, an, (t < 0) ? "R4" : "R5");
                for (int i = 0; i < lg; i++) begin
                    ref_rd(b | (AW'(1) << i), (t < 0) ? "R4" : "R5", v);
                    if ((t < 0 || i != t) && v != pt) begin
                        e_phase = 2'd2;
                        e_addr = (t < 0) ? (b | (AW'(1) << i)) : (b | toff);
                        e_data = v;
                        return;
                    end
                end
                ref_wr(b | toff, pt, (t < 0) ? "R4" : "R5");
            end
        end
        for (int k = 0; k < (1 << lg); k++) ref_wr(b | AW'(k), DW'(k + 1), "R6");
        for (int k = 0; k < (1 << lg); k++) begin
            ref_rd(b | AW'(k), "R6", v);
            if (v != DW'(k + 1)) begin e_phase = 2'd3; e_addr = b | AW'(k); e_data = v; return; end
            ref_wr(b | AW'(k), ~DW'(k + 1), "R6");
        end
        for (int k = 0; k < (1 << lg); k++) begin
            ref_rd(b | AW'(k), "R6", v);
            if (v != ~DW'(k + 1)) begin e_phase = 2'd3; e_addr = b | AW'(k); e_data = v; return; end
            ref_wr(b | AW'(k), '0, "R6");
        end
        e_pass = 1'b1;
    endtask

    // Per-clock comparison of port activity with the predicted list
    always @(negedge clk) begin
        if (rst_n && (mem_we || mem_re)) begin
            if (exp_q.size() == 0) begin
                chk("R8", {mem_we, mem_re, mem_addr}, 32'h0, "access after run end");
            end else begin
                op_t   o;
                string tg;
                o  = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(tg, {mem_we, mem_re, mem_addr, (mem_we ? mem_wdata : DW'(0))},
                        {o.we, o.re, o.a, o.d}, "port access");
            end
        end
    end

    task automatic do_run(input logic [AW-1:0] base, input int lg, input bit poke);
        ref_run(base, lg);
        @(negedge clk);
        base_addr = base;
        region_lg = LGW'(lg);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", busy, 1, "busy after start");
        if (poke) begin
            repeat (6) @(negedge clk);
            base_addr = base ^ 8'hFF;
            region_lg = LGW'(2);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R8", busy, 0, "busy at end");
        chk("R8", exp_q.size(), 0, "accesses left unissued");
        chk(e_pass ? "R9" : "R8", pass, e_pass, "pass flag");
        chk(e_pass ? "R9" : "R8", fail_phase, e_phase, "fail phase");
        if (!e_pass) begin
            chk("R8", fail_addr, e_addr, "fail address");
            chk("R8", fail_data, e_data, "fail data");
        end
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic chk_zero(input logic [AW-1:0] b, input int lg, input string req);
        int nz = 0;
        for (int k = 0; k < (1 << lg); k++) if (live_mem[b + AW'(k)] != '0) nz++;
        chk(req, nz, 0, "nonzero words left in region");
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] keep;
        for (int i = 0; i < NW; i++) live_mem[i] = DW'(i) ^ 8'hC3;
        live_last = '0;
        mem_rdata = '0;
        rst_n = 1'b0;
        start = 1'b0;
        base_addr = '0;
        region_lg = '0;
        repeat (4) @(negedge clk);
        chk("R1", {busy, done, pass, fail_phase}, 0, "status after reset");
        chk("R1", {mem_we, mem_re}, 0, "port quiet in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {busy, done, mem_we, mem_re}, 0, "idle after reset");

        // Clean region, aligned base
        do_run(8'h30, 4, 1'b0);
        chk_zero(8'h30, 4, "R9");
        repeat (10) @(negedge clk);
        chk("R9", {done, pass}, 2'b11, "result held while idle");

        // Unaligned base, second start in mid-run
        keep = live_mem[8'h48];
        do_run(8'h47, 3, 1'b1);
        chk_zero(8'h40, 3, "R10");
        chk("R10", live_mem[8'h48], keep, "word past region untouched");

        // One-word region: no address phase
        do_run(8'h91, 0, 1'b0);
        chk("R10", live_mem[8'h91], 0, "single word cleared");

        // Oversized region clamps to the whole memory
        do_run(8'h00, 15, 1'b0);
        chk_zero(8'h00, AW, "R10");

        // Data bit 5 stuck high: caught by the data phase
        fault_kind = 1; fault_bit = 5;
        do_run(8'h20, 4, 1'b0);
        chk("R3", {fail_phase, fail_addr, fail_data}, {2'd1, 8'h20, 8'h01}, "stuck data line report");

        // Missing chip: passes data phase, caught by address phase
        fault_kind = 3;
        do_run(8'h30, 4, 1'b0);
        chk("R4", {fail_phase, fail_addr, fail_data}, {2'd2, 8'h31, 8'h55}, "missing chip report");

        // Address bit 2 stuck low: offset 4 aliases offset 0
        fault_kind = 2; fault_bit = 2;
        do_run(8'h30, 4, 1'b0);
        chk("R4", {fail_phase, fail_addr, fail_data}, {2'd2, 8'h34, 8'h55}, "stuck low address report");

        // Address bit 1 stuck high
        fault_kind = 4; fault_bit = 1;
        do_run(8'h30, 4, 1'b0);
        chk("R4", fail_phase, 2'd2, "stuck high address phase");

        // Wired-OR short of bits 1 and 2: found by per-offset loop
        fault_kind = 6; fault_bit = 1;
        do_run(8'h30, 4, 1'b0);
        chk("R5", {fail_phase, fail_addr, fail_data}, {2'd2, 8'h32, 8'h55}, "short reports offset under test");

        // Stuck cell: only the device phase sees it
        fault_kind = 5; fault_cell = 8'h33;
        do_run(8'h30, 4, 1'b0);
        chk("R6", {fail_phase, fail_addr, fail_data}, {2'd3, 8'h33, 8'h84}, "stuck cell report");

        // Clean again after faults
        fault_kind = 0;
        do_run(8'hA0, 5, 1'b0);
        chk_zero(8'hA0, 5, "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule